// File: doc/BRIEF.md
# Sticky Out-of-Limit Alert Controller

The controller gathers fifteen out-of-limit flags from the monitoring logic around it into two banks of sticky status bits. From them it derives one active-low alert line. Bank A holds seven primary conditions. Bank B holds eight secondary conditions, and two of those eight can be fed from alternate sources. Each bank has a mask byte. A mask bit only keeps its source from pulling the alert low; the status bit still records the event.

Software reaches the block over a small synchronous register port. It reads the two status bytes and reads and writes the two mask bytes. A read of a status byte clears a bit only when the condition behind that bit has already gone away. Because of this, an event that is still active can never be lost by polling. The intended service sequence is: take the alert, read status, mask the source, handle it, then poll status and unmask once the bit has dropped. Bit 7 of mask A also acts as a group mask over all of bank B.

Top module: `alert_hub`

## Requirements
- R1: After synchronous reset, every status bit and mask bit is 0, `alert_n_o` is 1 and `rdata_o` is 0.
- R2: A condition that is high on a cycle sets its status bit on that clock edge, whatever the mask bits hold.
- R3: A status read of a bit whose condition is high in the read cycle leaves the bit set. This includes a condition that rises in that same cycle, in which case the read returns the bit's earlier value.
- R4: A status read clears each bit of the byte being read whose condition is low in that cycle. Bits in the other status byte are not touched.
- R5: `alert_n_o` is registered. After every edge it is 0 exactly when some status bit in bank A is set and unmasked, or some bit in bank B is set and unmasked while mask A bit 7 is 0.
- R6: Writing a mask bit to 1 lets the alert rise while the status bit stays set. Writing it back to 0 lets the alert fall again if the status bit is still set.
- R7: Mask A bit 7 set to 1 removes every bank B bit from the alert, and has no effect on bank A bits. In a read of status A, bit 7 returns the OR of all bank B status bits.
- R8: Mask A is at address 0x74 and mask B at 0x75. Both can be written and read back. Writes to any other address, including the status addresses, change nothing. A read of an unmapped address returns 0.
- R9: Bank B bit 5 follows `therm_i` when `therm_sel_i` is 1, and the fan-4 flag `cond_b_i[5]` otherwise. Bank B bit 0 follows `vid_i` when `vid_sel_i` is 1, and `cond_b_i[0]` otherwise.
- R10: Status A is read at 0x41 and status B at 0x42. Read data appears on `rdata_o` one cycle after the read strobe. Status A bits 6..0 map to `cond_a_i[6:0]`. Status B bits 7..0 map to `cond_b_i[7:0]` after the R9 selection, and mask bit n covers status bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_a_i | input | 7 | Bank A condition flags (remote 2, local, remote 1, 5 V, VCC, VCCP, 2.5 V from bit 6 down) |
| cond_b_i | input | 8 | Bank B condition flags (diode 2, diode 1, fan 4, fan 3, fan 2, fan 1, overtemperature, 12 V from bit 7 down) |
| therm_i | input | 1 | Alternate source for bank B bit 5 |
| vid_i | input | 1 | Alternate source for bank B bit 0 (identification code change) |
| therm_sel_i | input | 1 | Selects `therm_i` for bank B bit 5 |
| vid_sel_i | input | 1 | Selects `vid_i` for bank B bit 0 |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| alert_n_o | output | 1 | Registered active-low alert |

## Verification
The bench builds the block with its default 8-bit data and address widths. At that size the bank layout is fixed at seven plus eight sources, so every one of the fifteen sources can be walked through the full set–hold–clear cycle, once masked and once unmasked. The small size also makes the group mask and both source selectors cheap to cover completely. A same-cycle read-and-rise case and a mid-run reset close out the corner cases of the clear rule.

// File: rtl/alert_pkg.sv
package alert_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int BANK_A_W = DATA_W - 1;
  typedef logic [DATA_W-1:0] reg_byte_t;
endpackage

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cond,
  input  logic         rd_clr,
  output logic [W-1:0] q,
  output logic [W-1:0] d
);
  // one flop per source; the live condition always outranks a read-clear
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb d[i] = cond[i] | (q[i] & ~rd_clr);
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= d[i];
    end
  end
endmodule

// File: rtl/source_select.sv
module source_select #(
  parameter int W       = 8,
  parameter int THM_BIT = 5,
  parameter int VID_BIT = 0
) (
  input  logic [W-1:0] raw,
  input  logic         therm,
  input  logic         vid,
  input  logic         therm_sel,
  input  logic         vid_sel,
  output logic [W-1:0] eff
);
  always_comb begin
    eff          = raw;
    eff[THM_BIT] = therm_sel ? therm : raw[THM_BIT];
    eff[VID_BIT] = vid_sel   ? vid   : raw[VID_BIT];
  end
endmodule

// File: rtl/alert_gate.sv
module alert_gate #(
  parameter int AW = 7,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] stat_a_d,
  input  logic [BW-1:0] stat_b_d,
  input  logic [AW:0]   mask_a_d,
  input  logic [BW-1:0] mask_b_d,
  output logic          alert_n
);
  logic hit_a, hit_b;
  // evaluated on next-state values so the pin moves on the same edge as status
  always_comb begin
    hit_a = |(stat_a_d & ~mask_a_d[AW-1:0]);
    hit_b = ~mask_a_d[AW] & (|(stat_b_d & ~mask_b_d));
  end
  always_ff @(posedge clk) begin
    if (rst) alert_n <= 1'b1;
    else     alert_n <= ~(hit_a | hit_b);
  end
endmodule

// File: rtl/reg_port.sv
module reg_port #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] STAT_A_ADDR = 'h41,
  parameter logic [AW-1:0] STAT_B_ADDR = 'h42,
  parameter logic [AW-1:0] MASK_A_ADDR = 'h74,
  parameter logic [AW-1:0] MASK_B_ADDR = 'h75
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-2:0] stat_a,
  input  logic [DW-1:0] stat_b,
  output logic          clr_a,
  output logic          clr_b,
  output logic [DW-1:0] mask_a_q,
  output logic [DW-1:0] mask_a_d,
  output logic [DW-1:0] mask_b_q,
  output logic [DW-1:0] mask_b_d,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] rd_mux;

  always_comb begin
    clr_a    = rd_en && (addr == STAT_A_ADDR);
    clr_b    = rd_en && (addr == STAT_B_ADDR);
    mask_a_d = (wr_en && addr == MASK_A_ADDR) ? wdata : mask_a_q;
    mask_b_d = (wr_en && addr == MASK_B_ADDR) ? wdata : mask_b_q;
    case (addr)
      STAT_A_ADDR: rd_mux = {|stat_b, stat_a};
      STAT_B_ADDR: rd_mux = stat_b;
      MASK_A_ADDR: rd_mux = mask_a_q;
      MASK_B_ADDR: rd_mux = mask_b_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_a_q <= '0;
      mask_b_q <= '0;
      rdata    <= '0;
    end else begin
      mask_a_q <= mask_a_d;
      mask_b_q <= mask_b_d;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/alert_hub.sv
module alert_hub
  import alert_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] STAT_A_ADDR = 'h41,
  parameter logic [AW-1:0] STAT_B_ADDR = 'h42,
  parameter logic [AW-1:0] MASK_A_ADDR = 'h74,
  parameter logic [AW-1:0] MASK_B_ADDR = 'h75,
  parameter int THM_BIT = 5,
  parameter int VID_BIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-2:0] cond_a_i,
  input  logic [DW-1:0] cond_b_i,
  input  logic          therm_i,
  input  logic          vid_i,
  input  logic          therm_sel_i,
  input  logic          vid_sel_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          alert_n_o
);
  localparam int LO_W = DW - 1;

  logic [DW-1:0] cond_b_eff;
  logic [LO_W-1:0] stat_a_q, stat_a_d;
  logic [DW-1:0] stat_b_q, stat_b_d;
  logic [DW-1:0] mask_a_q, mask_a_d, mask_b_q, mask_b_d;
  logic clr_a, clr_b;

  source_select #(.W(DW), .THM_BIT(THM_BIT), .VID_BIT(VID_BIT)) u_sel (
    .raw(cond_b_i), .therm(therm_i), .vid(vid_i),
    .therm_sel(therm_sel_i), .vid_sel(vid_sel_i), .eff(cond_b_eff)
  );

  reg_port #(
    .DW(DW), .AW(AW),
    .STAT_A_ADDR(STAT_A_ADDR), .STAT_B_ADDR(STAT_B_ADDR),
    .MASK_A_ADDR(MASK_A_ADDR), .MASK_B_ADDR(MASK_B_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .rd_en(rd_en_i), .wr_en(wr_en_i),
    .addr(addr_i), .wdata(wdata_i), .stat_a(stat_a_q), .stat_b(stat_b_q),
    .clr_a(clr_a), .clr_b(clr_b),
    .mask_a_q(mask_a_q), .mask_a_d(mask_a_d),
    .mask_b_q(mask_b_q), .mask_b_d(mask_b_d), .rdata(rdata_o)
  );

  sticky_bank #(.W(LO_W)) u_bank_a (
    .clk(clk), .rst(rst), .cond(cond_a_i), .rd_clr(clr_a),
    .q(stat_a_q), .d(stat_a_d)
  );

  sticky_bank #(.W(DW)) u_bank_b (
    .clk(clk), .rst(rst), .cond(cond_b_eff), .rd_clr(clr_b),
    .q(stat_b_q), .d(stat_b_d)
  );

  alert_gate #(.AW(LO_W), .BW(DW)) u_gate (
    .clk(clk), .rst(rst), .stat_a_d(stat_a_d), .stat_b_d(stat_b_d),
    .mask_a_d(mask_a_d), .mask_b_d(mask_b_d), .alert_n(alert_n_o)
  );
endmodule

// File: rtl/alert_hub_chk.sv
module alert_hub_chk #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] STAT_A_ADDR = 'h41,
  parameter logic [AW-1:0] MASK_A_ADDR = 'h74
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-2:0] cond_a_i,
  input logic          rd_en_i,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          alert_n_o,
  input logic [DW-2:0] stat_a_q,
  input logic [DW-1:0] stat_b_q,
  input logic [DW-1:0] mask_a_q
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (alert_n_o && rdata_o == '0));

  assert_cond_sets_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_a_q & $past(cond_a_i)) == $past(cond_a_i)));

  assert_hold_without_read_R3: assert property (@(posedge clk) disable iff (rst)
    !(rd_en_i && addr_i == STAT_A_ADDR) |=> ((stat_a_q & $past(stat_a_q)) == $past(stat_a_q)));

  assert_alert_needs_status_R5: assert property (@(posedge clk) disable iff (rst)
    !alert_n_o |-> (stat_a_q != '0 || stat_b_q != '0));

  assert_full_mask_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (mask_a_q == '1) |-> alert_n_o);

  assert_mask_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == MASK_A_ADDR) |=> (mask_a_q == $past(wdata_i)));
endmodule

bind alert_hub alert_hub_chk #(
  .DW(DW), .AW(AW), .STAT_A_ADDR(STAT_A_ADDR), .MASK_A_ADDR(MASK_A_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .cond_a_i(cond_a_i), .rd_en_i(rd_en_i),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .alert_n_o(alert_n_o), .stat_a_q(stat_a_q), .stat_b_q(stat_b_q),
  .mask_a_q(mask_a_q)
);

// File: tb/alert_hub_test.sv
`timescale 1ns/1ps
module alert_hub_test;
  localparam logic [7:0] SA = 8'h41, SB = 8'h42, MA = 8'h74, MB = 8'h75;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] ca = '0;
  logic [7:0] cb = '0;
  logic therm = 0, vid = 0, tsel = 0, vsel = 0;
  logic rd_en = 0, wr_en = 0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic alert_n;

  int checks = 0, fails = 0;
  logic [6:0] m_sa = '0;
  logic [7:0] m_sb = '0, m_ma = '0, m_mb = '0;

  always #2 clk = ~clk;

  alert_hub uut (
    .clk(clk), .rst(rst), .cond_a_i(ca), .cond_b_i(cb), .therm_i(therm),
    .vid_i(vid), .therm_sel_i(tsel), .vid_sel_i(vsel), .rd_en_i(rd_en),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .alert_n_o(alert_n)
  );

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  function automatic logic exp_alert();
    return !((|(m_sa & ~m_ma[6:0])) || (!m_ma[7] && (|(m_sb & ~m_mb))));
  endfunction

  function automatic logic [7:0] model_read(input logic [7:0] a);
    case (a)
      SA: return {|m_sb, m_sa};
      SB: return m_sb;
      MA: return m_ma;
      MB: return m_mb;
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(input string tag, input logic rd, input logic wr,
                      input logic [7:0] a, input logic [7:0] d);
    logic [7:0] eb, er;
    rd_en = rd; wr_en = wr; addr = a; wdata = d;
    eb = cb;
    eb[5] = tsel ? therm : cb[5];
    eb[0] = vsel ? vid : cb[0];
    er = model_read(a);
    m_sa = ca | ((rd && a == SA) ? 7'h00 : m_sa);
    m_sb = eb | ((rd && a == SB) ? 8'h00 : m_sb);
    if (wr && a == MA) m_ma = d;
    if (wr && a == MB) m_mb = d;
    @(posedge clk); @(negedge clk);
    rd_en = 0; wr_en = 0;
    check(tag, "alert_n", {7'h0, alert_n}, {7'h0, exp_alert()});
    if (rd) check(tag, "rdata", rdata, er);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    m_sa = '0; m_sb = '0; m_ma = '0; m_mb = '0;
    check("R1", "alert_n", {7'h0, alert_n}, 8'h01);
    check("R1", "rdata", rdata, 8'h00);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    step("R1", 1, 0, SA, 0); step("R1", 1, 0, SB, 0);
    step("R1", 1, 0, MA, 0); step("R1", 1, 0, MB, 0);

    // every source, unmasked then masked
    for (int i = 0; i < 15; i++) begin
      for (int m = 0; m < 2; m++) begin
        logic [7:0] own, other, maddr, mval;
        own   = (i < 7) ? SA : SB;
        other = (i < 7) ? SB : SA;
        maddr = (i < 7) ? MA : MB;
        mval  = m ? (8'h01 << ((i < 7) ? i : i - 7)) : 8'h00;
        step("R8", 0, 1, maddr, mval);
        if (i < 7) ca[i] = 1'b1; else cb[i-7] = 1'b1;
        step("R2", 0, 0, 0, 0);
        step(m ? "R6" : "R5", 0, 0, 0, 0);
        step("R3", 1, 0, own, 0);
        if (m) step("R6", 0, 1, maddr, 8'h00);
        ca = '0; cb = '0;
        step("R5", 0, 0, 0, 0);
        step("R4", 1, 0, other, 0);
        step("R10", 1, 0, own, 0);
        step("R4", 1, 0, own, 0);
      end
    end

    // group mask over bank B
    step("R7", 0, 1, MA, 8'h80);
    cb = 8'hFF;
    step("R7", 0, 0, 0, 0);
    step("R7", 1, 0, SB, 0);
    step("R7", 1, 0, SA, 0);
    ca = 7'h01;
    step("R7", 0, 0, 0, 0);
    ca = '0;
    step("R7", 1, 0, SA, 0);
    step("R7", 0, 1, MA, 8'h00);
    cb = '0;
    step("R7", 1, 0, SB, 0);
    step("R7", 1, 0, SA, 0);

    // condition rising in the read cycle wins
    ca = 7'h04;
    step("R3", 1, 0, SA, 0);
    ca = '0;
    step("R3", 1, 0, SA, 0);
    step("R3", 1, 0, SA, 0);

    // register map and ignored writes
    step("R8", 0, 1, SA, 8'hFF);
    step("R8", 0, 1, SB, 8'hFF);
    step("R8", 1, 0, SA, 0);
    step("R8", 1, 0, SB, 0);
    step("R8", 1, 0, 8'h00, 0);
    step("R8", 0, 1, MA, 8'hA5);
    step("R8", 0, 1, MB, 8'h3C);
    step("R8", 1, 0, MA, 0);
    step("R8", 1, 0, MB, 0);
    step("R8", 0, 1, MA, 8'h00);
    step("R8", 0, 1, MB, 8'h00);

    // alternate sources
    tsel = 1; vsel = 1; cb = 8'h21;
    step("R9", 0, 0, 0, 0);
    step("R9", 1, 0, SB, 0);
    cb = '0; therm = 1; vid = 1;
    step("R9", 0, 0, 0, 0);
    therm = 0; vid = 0;
    step("R9", 1, 0, SB, 0);
    step("R9", 1, 0, SB, 0);
    tsel = 0; vsel = 0;

    // bit layout pattern
    ca = 7'h55;
    step("R10", 0, 0, 0, 0);
    ca = '0;
    step("R10", 1, 0, SA, 0);

    // mid-run reset
    ca = 7'h7F; cb = 8'hFF;
    step("R1", 0, 1, MB, 8'hFF);
    ca = '0; cb = '0;
    do_reset();
    step("R1", 1, 0, SA, 0); step("R1", 1, 0, SB, 0); step("R1", 1, 0, MB, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule